// File: doc/BRIEF.md
# USB Charger Type Detection Sequencer

This block works out what kind of port a USB device is plugged into, so that charging current can be chosen before enumeration. After a start pulse it checks VBUS, parks the PHY in suspend with the controller in non-driving mode, and runs three timed phases. The first phase detects data contact. The second phase, primary detection, tells a charging port from a standard host port. The third phase, secondary detection, tells a dedicated charger from a charging host port. In each phase it closes one pair of analog switches on D+ and D- and reads one comparator status at the end of the phase window. It then restores the PHY and reports a 3-bit result code.

All timing is in ticks. A prescaler divides the clock by `TICK_DIV` to make one tick, and each phase length is a tick count parameter, so a real design and a short simulation use the same RTL. Every pin is a plain level or pulse. Nothing streams through the block, so no valid/ready handshake is used. A start pulse is a one-cycle request. `done_o` is a level that holds, with `result_o` and `data_capable_o`, until the next accepted start.

Top module: `usb_chg_classifier`

## Requirements
- R1: If `vbus_ok_i` is low when an idle block sees `start_i`, then on the next cycle `done_o` is 1 and `result_o` is 0 (unknown). `busy_o`, the PHY controls and all analog enables stay low for the whole run.
- R2: `phy_suspend_o` and `opmode_nodrive_o` rise together at least one cycle before any analog enable. Every analog enable is active only while both are high. When detection ends, `opmode_nodrive_o` falls at least one cycle before `phy_suspend_o` falls.
- R3: Contact detection drives `dm_pulldown_o` and `dp_isrc_o`. It samples `contact_st_i` at the end of each window of `CONTACT_POLL_TICKS*TICK_DIV` cycles. It stops at the first window in which contact is seen, or after `CONTACT_MAX_POLLS` windows.
- R4: After contact detection, the contact switches open and `dp_vsrc_o` and `dm_isink_o` close for one window of `PRIMARY_TICKS*TICK_DIV` cycles. `port_st_i` is sampled in the last cycle of the window.
- R5: If the first primary window fails and contact was never seen, the result is 4 (floating). No further window follows.
- R6: If the first primary window fails after contact was seen, up to `PRIMARY_RETRIES` more primary windows run, each after one cycle with the switches open. If every window fails, the result is 1 (standard downstream port).
- R7: After a primary window succeeds, `dm_vsrc_o` and `dp_isink_o` close for `SECONDARY_TICKS*TICK_DIV` cycles. `ded_st_i` is then sampled: 1 gives result 2 (dedicated charger), 0 gives result 3 (charging downstream port).
- R8: At most one switch group is closed in any cycle: contact, primary or secondary.
- R9: A start pulse while `busy_o` is high is ignored. The run in progress keeps its timing and its result.
- R10: `done_o` is low while `busy_o` is high. `done_o` and `result_o` hold their values while idle until the next start pulse.
- R11: `data_capable_o` is high only when `done_o` is high and the result is 1 or 3.
- R12: After reset, `busy_o`, `done_o`, `data_capable_o`, the PHY controls and all enables are low, and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to classify the port |
| vbus_ok_i | input | 1 | VBUS valid from the PHY |
| contact_st_i | input | 1 | Data-contact comparator status |
| port_st_i | input | 1 | Charging-port comparator status (primary) |
| ded_st_i | input | 1 | Dedicated-charger comparator status (secondary) |
| phy_suspend_o | output | 1 | Holds the PHY in suspend |
| opmode_nodrive_o | output | 1 | Puts the controller in non-driving mode |
| dm_pulldown_o | output | 1 | D- pull-down resistor enable |
| dp_isrc_o | output | 1 | D+ current source enable |
| dp_vsrc_o | output | 1 | D+ voltage source enable |
| dm_isink_o | output | 1 | D- current sink enable |
| dm_vsrc_o | output | 1 | D- voltage source enable |
| dp_isink_o | output | 1 | D+ current sink enable |
| busy_o | output | 1 | Detection in progress |
| done_o | output | 1 | Result valid, held until next start |
| result_o | output | 3 | 0 unknown, 1 standard, 2 dedicated, 3 charging host, 4 floating |
| data_capable_o | output | 1 | The attached port can carry data |

## Verification
The hardest paths to reach are the ones that depend on when a comparator answers. Two cases matter most: contact seen only in the very last poll, and primary success only in the final retry window. The stimulus includes a bench model of the analog front end. It counts the enabled cycles and primary windows as they happen, and raises each status from a chosen poll or window index. This gives a random mix of contact index (including never), success window (including never) and dedicated flag. The runs also include extra start pulses sent mid-run.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    RES_UNKNOWN   = 3'd0,
    RES_STD_PORT  = 3'd1,
    RES_DEDICATED = 3'd2,
    RES_CHG_HOST  = 3'd3,
    RES_FLOATING  = 3'd4
  } chg_res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_CONTACT,
    ST_PRIMARY,
    ST_PRI_GAP,
    ST_SECONDARY,
    ST_RESTORE
  } chg_state_e;

endpackage

// File: rtl/chg_tick_gen.sv
// Divides the clock into ticks; restarts its count when a phase is loaded
// so that every window is an exact multiple of DIV cycles.
module chg_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/chg_phase_timer.sv
// Counts down a phase length in ticks; expire_o marks the last cycle.
module chg_phase_timer #(
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [LW-1:0] left_q;

  assign expire_o = tick_i && (left_q == LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          left_q <= '0;
    else if (load_i)                     left_q <= len_i;
    else if (tick_i && (left_q != '0))   left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/chg_seq_fsm.sv
// Phase sequencer: contact polls, primary windows with retries,
// secondary window, then ordered restore of the PHY controls.
module chg_seq_fsm
  import chg_pkg::*;
#(
  parameter int unsigned LW          = 8,
  parameter int unsigned MAX_POLLS   = 6,
  parameter int unsigned RETRIES     = 2,
  parameter int unsigned CONTACT_LEN = 100,
  parameter int unsigned PRIMARY_LEN = 40,
  parameter int unsigned SECOND_LEN  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          vbus_ok_i,
  input  logic          contact_st_i,
  input  logic          port_st_i,
  input  logic          ded_st_i,
  input  logic          expire_i,
  output logic          load_o,
  output logic [LW-1:0] len_o,
  output logic          suspend_o,
  output logic          nodrive_o,
  output logic          grp_contact_o,
  output logic          grp_primary_o,
  output logic          grp_second_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    result_o
);
  localparam int unsigned PW = $clog2(MAX_POLLS + 1);
  localparam int unsigned RW = (RETRIES > 0) ? $clog2(RETRIES + 1) : 1;
  localparam logic [PW-1:0] POLLS_INIT = PW'(MAX_POLLS);
  localparam logic [RW-1:0] RETRY_INIT = RW'(RETRIES);

  chg_state_e    state_q, state_d;
  logic [PW-1:0] polls_left_q;
  logic [RW-1:0] retries_left_q;
  logic          contact_seen_q;
  logic          done_q;
  chg_res_e      result_q;

  logic accept;
  logic contact_done;
  logic pri_fail;

  assign accept       = (state_q == ST_IDLE) && start_i;
  assign contact_done = contact_st_i || (polls_left_q == PW'(1));
  assign pri_fail     = !port_st_i;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    len_o   = LW'(CONTACT_LEN);
    unique case (state_q)
      ST_IDLE:
        if (accept && vbus_ok_i) state_d = ST_PREP;
      ST_PREP: begin
        state_d = ST_CONTACT;
        load_o  = 1'b1;
        len_o   = LW'(CONTACT_LEN);
      end
      ST_CONTACT:
        if (expire_i) begin
          load_o = 1'b1;
          if (contact_done) begin
            state_d = ST_PRIMARY;
            len_o   = LW'(PRIMARY_LEN);
          end else begin
            len_o   = LW'(CONTACT_LEN);
          end
        end
      ST_PRIMARY:
        if (expire_i) begin
          if (!pri_fail) begin
            state_d = ST_SECONDARY;
            load_o  = 1'b1;
            len_o   = LW'(SECOND_LEN);
          end else if (contact_seen_q && (retries_left_q != '0)) begin
            state_d = ST_PRI_GAP;
          end else begin
            state_d = ST_RESTORE;
          end
        end
      ST_PRI_GAP: begin
        state_d = ST_PRIMARY;
        load_o  = 1'b1;
        len_o   = LW'(PRIMARY_LEN);
      end
      ST_SECONDARY:
        if (expire_i) state_d = ST_RESTORE;
      ST_RESTORE:
        state_d = ST_IDLE;
      default:
        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      polls_left_q   <= '0;
      retries_left_q <= '0;
      contact_seen_q <= 1'b0;
      done_q         <= 1'b0;
      result_q       <= RES_UNKNOWN;
    end else begin
      state_q <= state_d;
      if (accept) begin
        result_q       <= RES_UNKNOWN;
        done_q         <= !vbus_ok_i;
        polls_left_q   <= POLLS_INIT;
        retries_left_q <= RETRY_INIT;
        contact_seen_q <= 1'b0;
      end
      if ((state_q == ST_CONTACT) && expire_i) begin
        polls_left_q <= polls_left_q - 1'b1;
        if (contact_st_i) contact_seen_q <= 1'b1;
      end
      if ((state_q == ST_PRIMARY) && expire_i && pri_fail) begin
        if (!contact_seen_q)             result_q       <= RES_FLOATING;
        else if (retries_left_q != '0)   retries_left_q <= retries_left_q - 1'b1;
        else                             result_q       <= RES_STD_PORT;
      end
      if ((state_q == ST_SECONDARY) && expire_i)
        result_q <= ded_st_i ? RES_DEDICATED : RES_CHG_HOST;
      if (state_q == ST_RESTORE) done_q <= 1'b1;
    end
  end

  always_comb begin
    suspend_o     = 1'b0;
    nodrive_o     = 1'b0;
    grp_contact_o = 1'b0;
    grp_primary_o = 1'b0;
    grp_second_o  = 1'b0;
    unique case (state_q)
      ST_PREP, ST_PRI_GAP: begin
        suspend_o = 1'b1; nodrive_o = 1'b1;
      end
      ST_CONTACT: begin
        suspend_o = 1'b1; nodrive_o = 1'b1; grp_contact_o = 1'b1;
      end
      ST_PRIMARY: begin
        suspend_o = 1'b1; nodrive_o = 1'b1; grp_primary_o = 1'b1;
      end
      ST_SECONDARY: begin
        suspend_o = 1'b1; nodrive_o = 1'b1; grp_second_o = 1'b1;
      end
      ST_RESTORE:
        suspend_o = 1'b1;
      default: ;
    endcase
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/usb_chg_classifier.sv
module usb_chg_classifier #(
  parameter int unsigned TICK_DIV           = 1000,
  parameter int unsigned CONTACT_POLL_TICKS = 100,
  parameter int unsigned CONTACT_MAX_POLLS  = 6,
  parameter int unsigned PRIMARY_TICKS      = 40,
  parameter int unsigned PRIMARY_RETRIES    = 2,
  parameter int unsigned SECONDARY_TICKS    = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       vbus_ok_i,
  input  logic       contact_st_i,
  input  logic       port_st_i,
  input  logic       ded_st_i,
  output logic       phy_suspend_o,
  output logic       opmode_nodrive_o,
  output logic       dm_pulldown_o,
  output logic       dp_isrc_o,
  output logic       dp_vsrc_o,
  output logic       dm_isink_o,
  output logic       dm_vsrc_o,
  output logic       dp_isink_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [2:0] result_o,
  output logic       data_capable_o
);
  localparam int unsigned LEN_A   = (CONTACT_POLL_TICKS > PRIMARY_TICKS) ?
                                    CONTACT_POLL_TICKS : PRIMARY_TICKS;
  localparam int unsigned LEN_MAX = (LEN_A > SECONDARY_TICKS) ? LEN_A : SECONDARY_TICKS;
  localparam int unsigned LW      = $clog2(LEN_MAX + 1);

  logic          tick;
  logic          load;
  logic [LW-1:0] len;
  logic          expire;
  logic          grp_contact, grp_primary, grp_second;

  chg_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (load),
    .tick_o    (tick)
  );

  chg_phase_timer #(.LW(LW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .len_i    (len),
    .tick_i   (tick),
    .expire_o (expire)
  );

  chg_seq_fsm #(
    .LW          (LW),
    .MAX_POLLS   (CONTACT_MAX_POLLS),
    .RETRIES     (PRIMARY_RETRIES),
    .CONTACT_LEN (CONTACT_POLL_TICKS),
    .PRIMARY_LEN (PRIMARY_TICKS),
    .SECOND_LEN  (SECONDARY_TICKS)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .vbus_ok_i     (vbus_ok_i),
    .contact_st_i  (contact_st_i),
    .port_st_i     (port_st_i),
    .ded_st_i      (ded_st_i),
    .expire_i      (expire),
    .load_o        (load),
    .len_o         (len),
    .suspend_o     (phy_suspend_o),
    .nodrive_o     (opmode_nodrive_o),
    .grp_contact_o (grp_contact),
    .grp_primary_o (grp_primary),
    .grp_second_o  (grp_second),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .result_o      (result_o)
  );

  assign dm_pulldown_o  = grp_contact;
  assign dp_isrc_o      = grp_contact;
  assign dp_vsrc_o      = grp_primary;
  assign dm_isink_o     = grp_primary;
  assign dm_vsrc_o      = grp_second;
  assign dp_isink_o     = grp_second;
  assign data_capable_o = done_o && ((result_o == 3'd1) || (result_o == 3'd3));
endmodule

// File: rtl/usb_chg_classifier_chk.sv
module usb_chg_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       vbus_ok_i,
  input logic       phy_suspend_o,
  input logic       opmode_nodrive_o,
  input logic       dm_pulldown_o,
  input logic       dp_isrc_o,
  input logic       dp_vsrc_o,
  input logic       dm_isink_o,
  input logic       dm_vsrc_o,
  input logic       dp_isink_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] result_o,
  input logic       data_capable_o
);
  logic any_en;
  assign any_en = dm_pulldown_o | dp_isrc_o | dp_vsrc_o | dm_isink_o | dm_vsrc_o | dp_isink_o;

  // R2
  enables_in_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_en |-> (phy_suspend_o && opmode_nodrive_o));

  // R2
  restore_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_suspend_o) |-> $past(!opmode_nodrive_o));

  // R8
  one_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dm_pulldown_o | dp_isrc_o, dp_vsrc_o | dm_isink_o, dm_vsrc_o | dp_isink_o}) <= 1);

  // R1
  no_vbus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !vbus_ok_i) |=>
      (done_o && (result_o == 3'd0) && !phy_suspend_o && !busy_o));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(result_o) && $stable(done_o)));

  // R11
  capable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_capable_o |-> (done_o && ((result_o == 3'd1) || (result_o == 3'd3))));
endmodule

bind usb_chg_classifier usb_chg_classifier_chk u_chk (.*);

// File: tb/usb_chg_classifier_tb.sv
module usb_chg_classifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int CPT   = 5;
  localparam int POLLS = 6;
  localparam int PRT   = 3;
  localparam int RETR  = 2;
  localparam int SCT   = 2;
  localparam int W_DCD = CPT * DIV;
  localparam int W_PRI = PRT * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, vbus_ok_i = 1'b0;
  logic contact_st_i = 1'b0, port_st_i = 1'b0, ded_st_i = 1'b0;
  logic phy_suspend_o, opmode_nodrive_o, dm_pulldown_o, dp_isrc_o;
  logic dp_vsrc_o, dm_isink_o, dm_vsrc_o, dp_isink_o;
  logic busy_o, done_o, data_capable_o;
  logic [2:0] result_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_chg_classifier #(
    .TICK_DIV(DIV), .CONTACT_POLL_TICKS(CPT), .CONTACT_MAX_POLLS(POLLS),
    .PRIMARY_TICKS(PRT), .PRIMARY_RETRIES(RETR), .SECONDARY_TICKS(SCT)
  ) u_dut (.*);

  int errors = 0, checks = 0;
  bit reported = 0;

  // front-end model state
  bit clr = 0;
  int m_k = 7, m_m = 4;
  bit m_ded = 0;
  int cyc = 0, dcd_cnt = 0, pri_cyc = 0, pri_win = 0, sec_win = 0;
  int t_su_rise = -1, t_en = -1, t_nd_fall = -1, t_su_fall = -1;
  bit su_seen = 0, p_pv = 0, p_mv = 0, p_su = 0, p_nd = 0;

  always @(negedge clk) begin
    cyc++;
    if (clr) begin
      dcd_cnt = 0; pri_cyc = 0; pri_win = 0; sec_win = 0; su_seen = 0;
      t_su_rise = -1; t_en = -1; t_nd_fall = -1; t_su_fall = -1;
    end else begin
      if (dm_pulldown_o) dcd_cnt++;
      if (dp_vsrc_o) begin pri_cyc++; if (!p_pv) pri_win++; end
      if (dm_vsrc_o && !p_mv) sec_win++;
      if (phy_suspend_o) su_seen = 1;
      if (phy_suspend_o && !p_su && t_su_rise < 0) t_su_rise = cyc;
      if ((dm_pulldown_o | dp_vsrc_o | dm_vsrc_o) && t_en < 0) t_en = cyc;
      if (p_nd && !opmode_nodrive_o) t_nd_fall = cyc;
      if (p_su && !phy_suspend_o) t_su_fall = cyc;
    end
    p_pv = dp_vsrc_o; p_mv = dm_vsrc_o; p_su = phy_suspend_o; p_nd = opmode_nodrive_o;
    contact_st_i = dm_pulldown_o && (dcd_cnt > (m_k - 1) * W_DCD);
    port_st_i    = dp_vsrc_o && (pri_win >= m_m);
    ded_st_i     = dm_vsrc_o && m_ded;
  end

  function automatic int exp_result(bit vb, int k, int m, bit ded);
    if (!vb) return 0;
    if (m == 1 || (k <= POLLS && m <= RETR + 1)) return ded ? 2 : 3;
    if (k > POLLS) return 4;
    return 1;
  endfunction

  function automatic int exp_windows(bit vb, int k, int m);
    if (!vb) return 0;
    if (m == 1 || k > POLLS) return 1;
    return (m <= RETR + 1) ? m : RETR + 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic run_case(bit vb, int k, int m, bit ded, bit mid);
    int res, win, guard, held;
    res = exp_result(vb, k, m, ded);
    win = exp_windows(vb, k, m);
    @(posedge clk); #2;
    clr = 1; m_k = k; m_m = m; m_ded = ded; vbus_ok_i = vb;
    @(posedge clk); #2;
    clr = 0; start_i = 1;
    @(posedge clk); #2;
    start_i = 0;
    if (!vb) begin
      check("R1 done immediately", done_o, 1);
      check("R1 not busy", busy_o, 0);
    end else begin
      check("R10 done low while busy", done_o, 0);
      check("R10 busy after start", busy_o, 1);
    end
    if (mid) begin
      repeat (30) @(posedge clk);
      #2 start_i = 1;
      @(posedge clk); #2 start_i = 0;
    end
    guard = 0;
    while (!(done_o && !busy_o) && guard < 5000) begin
      @(posedge clk); #2; guard++;
    end
    @(negedge clk); #1;
    check(mid ? "R9 result with ignored start" : "R5/R6/R7 result", result_o, res);
    check("R11 data capable", data_capable_o, (res == 1 || res == 3) ? 1 : 0);
    if (!vb) begin
      check("R1 suspend untouched", su_seen, 0);
      check("R1 no contact enable", dcd_cnt, 0);
    end else begin
      check("R3 contact cycles", dcd_cnt, ((k < POLLS) ? k : POLLS) * W_DCD);
      check("R4 primary windows", pri_win, win);
      check("R4 primary cycles", pri_cyc, win * W_PRI);
      check("R7 secondary windows", sec_win, (res == 2 || res == 3) ? 1 : 0);
      check("R2 suspend before enables", (t_su_rise >= 0 && t_su_rise < t_en) ? 1 : 0, 1);
      check("R2 opmode restored before suspend release",
            (t_nd_fall >= 0 && t_nd_fall < t_su_fall) ? 1 : 0, 1);
    end
    held = result_o;
    repeat (6) @(posedge clk);
    #2;
    check("R10 done held", done_o, 1);
    check("R10 result held", result_o, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check("R12 busy", busy_o, 0);
    check("R12 done", done_o, 0);
    check("R12 result", result_o, 0);
    check("R12 suspend/nodrive", {phy_suspend_o, opmode_nodrive_o}, 0);
    check("R12 enables", {dm_pulldown_o, dp_isrc_o, dp_vsrc_o, dm_isink_o, dm_vsrc_o, dp_isink_o}, 0);
    check("R12 data capable", data_capable_o, 0);

    run_case(0, 1, 1, 0, 0);   // R1
    run_case(1, 1, 1, 1, 0);   // R7 dedicated
    run_case(1, 3, 1, 0, 0);   // R7 charging host
    run_case(1, 7, 2, 0, 0);   // R5 floating
    run_case(1, 6, 4, 0, 0);   // R6 contact on last poll, all retries fail
    run_case(1, 2, 3, 1, 0);   // R6 success on final retry
    run_case(1, 7, 1, 0, 0);   // R4 primary ok without contact
    run_case(1, 2, 4, 0, 1);   // R9 start while busy
    run_case(0, 3, 2, 1, 0);   // R1 after a completed run

    for (int i = 0; i < 30; i++) begin
      bit vb, ded, mid;
      int k, m;
      vb  = ($urandom % 8) != 0;
      k   = 1 + int'($urandom % 7);
      m   = 1 + int'($urandom % 4);
      ded = 1'($urandom % 2);
      mid = ($urandom % 4) == 0;
      run_case(vb, k, m, ded, mid);
    end
    report();
  end
endmodule